// File: doc/BRIEF.md
# Banked DSP SRAM with address multiplexer

A clocked model of a single-port static memory meant to sit directly on a DSP data bus. The word address is built from a group of low address bits plus one top bit. That top bit is picked from two candidate inputs by a half-select line. Tying the half-select to a high-order bus address lets one array hold program words in one half and X or Y data operands in the other. The array is repartitioned on every access, with no glue logic.

Two enables of opposite polarity must both be active for the part to respond. An active-low output enable and an active-low write strobe choose between read, output-disable and write. All control inputs are sampled on one clock. A write lasts as long as both enables and the write strobe are active together. The word is committed when that window closes, using the address and data seen on the last clock of the window. The read bus carries a separate drive flag in place of a tri-state pin. A standby flag and a protocol-error pulse are also provided.

The default build has 10 low bits, giving 2048 words. Setting `LO_W` to 12 gives the full 8192 × 24 organisation.

Top module: `dsp_bank_sram`

## Requirements
- R1: The effective address is {top bit, `addr_lo`}. The top bit is `hi_alt` when `half_sel` is 1 and `hi_main` when `half_sel` is 0. The input that is not selected has no effect.
- R2: The part is deselected when `en_lo_n` is 1 or `en_hi` is 0. In that state no word is written and `drive_en` is 0. `standby` is 1 after every clock edge that samples deselect. During reset `standby` is 1, `drive_en` and `proto_err` are 0, and `rdata` is 0.
- R3: When the part is selected with `we_n` = 1 and `oe_n` = 1, `drive_en` is 0 and `standby` is 0 after the edge.
- R4: A read condition is: selected, `we_n` = 1 and `oe_n` = 0. When it is sampled at an edge, `rdata` holds the addressed word after that edge. `drive_en` is 1 for as long as the read condition still holds, and drops in the same cycle the condition drops. Back-to-back reads return one word per clock.
- R5: A write window is the run of clocks on which the part is selected with `we_n` = 0, whatever `oe_n` is. The window may close through `we_n` rising, `en_lo_n` rising or `en_hi` falling. On the closing edge, the address and data sampled on the window's last clock are committed.
- R6: `drive_en` is never 1 while `we_n` is 0. This holds even when `oe_n` is low during the write.
- R7: An edge inside an open window where `addr_lo`, `hi_main`, `hi_alt` or `half_sel` differs from the previous clock raises `proto_err` for exactly one cycle.
- R8: A read sampled on the edge that commits a write to the same address returns the newly committed word.
- R9: `rdata` keeps its value on every cycle that follows an edge with no read condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_lo | input | LO_W | Low address bits |
| hi_main | input | 1 | Top-bit candidate used when half_sel is 0 |
| hi_alt | input | 1 | Top-bit candidate used when half_sel is 1 |
| half_sel | input | 1 | Chooses the top-bit candidate |
| en_lo_n | input | 1 | Enable, active low |
| en_hi | input | 1 | Enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| drive_en | output | 1 | High when rdata is being driven |
| standby | output | 1 | High after a deselected edge |
| proto_err | output | 1 | One-cycle pulse on an address or select change inside a write window |

## Verification
A corrupted window-open flag or held address in the write path never shows while a write is in progress. It appears only at the first later read of the affected word, as stale data or as data in the wrong half. The bench therefore reads back every word it writes, and it reads both halves through both top-bit candidates. A broken drive gate shows in the same cycle, because `drive_en` is compared against a queue of expected reads on every clock. A broken change detector shows as `proto_err` rising or staying low one cycle after the stimulus.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    typedef enum logic [1:0] {
        ACC_OFF   = 2'd0,
        ACC_QUIET = 2'd1,
        ACC_READ  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_t;

    // Priority: deselect, then write strobe, then output enable.
    function automatic acc_t decode_access(input logic en_lo_n, input logic en_hi,
                                           input logic oe_n, input logic we_n);
        if (en_lo_n || !en_hi) return ACC_OFF;
        if (!we_n)             return ACC_WRITE;
        if (!oe_n)             return ACC_READ;
        return ACC_QUIET;
    endfunction

endpackage

// File: rtl/dsr_addr_mux.sv
module dsr_addr_mux #(
    parameter int LO_W = 10
) (
    input  logic [LO_W-1:0] addr_lo,
    input  logic            hi_main,
    input  logic            hi_alt,
    input  logic            half_sel,
    output logic [LO_W:0]   eff_addr
);
    logic top_bit;

    always_comb begin
        top_bit  = half_sel ? hi_alt : hi_main;
        eff_addr = {top_bit, addr_lo};
    end
endmodule

// File: rtl/dsr_wr_window.sv
module dsr_wr_window #(
    parameter int AW = 11,
    parameter int DW = 24,
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cond,
    input  logic [AW-1:0] eff_addr,
    input  logic [TW-1:0] tag,
    input  logic [DW-1:0] wdata,
    output logic          commit,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data,
    output logic          proto_err
);
    typedef struct packed {
        logic          open;
        logic          err;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [TW-1:0] tag;
    } win_t;

    win_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr_cond) begin
            st_d.err  = st_q.open && (tag != st_q.tag);
            st_d.open = 1'b1;
            st_d.addr = eff_addr;
            st_d.data = wdata;
            st_d.tag  = tag;
        end else begin
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit      = st_q.open && !wr_cond;
    assign commit_addr = st_q.addr;
    assign commit_data = st_q.data;
    assign proto_err   = st_q.err;

    // R7: an error pulse follows only an edge that saw an active write
    p_err_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(wr_cond));
endmodule

// File: rtl/dsr_array.sv
module dsr_array #(
    parameter int AW = 11,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [AW-1:0] commit_addr,
    input  logic [DW-1:0] commit_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rdata,
    output logic          rd_valid
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] rdata;
    } rd_t;

    rd_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic          hit;

    always_ff @(posedge clk) begin
        if (commit) mem[commit_addr] <= commit_data;
    end

    always_comb begin
        st_d       = st_q;
        hit        = commit && (commit_addr == rd_addr);
        st_d.valid = rd_req;
        if (rd_req) st_d.rdata = hit ? commit_data : mem[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata    = st_q.rdata;
    assign rd_valid = st_q.valid;

    // R9: read data holds after an edge without a read request
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_req) |-> $stable(rdata));
endmodule

// File: rtl/dsp_bank_sram.sv
module dsp_bank_sram #(
    parameter int LO_W = 10,
    parameter int DW   = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LO_W-1:0] addr_lo,
    input  logic            hi_main,
    input  logic            hi_alt,
    input  logic            half_sel,
    input  logic            en_lo_n,
    input  logic            en_hi,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            drive_en,
    output logic            standby,
    output logic            proto_err
);
    import dsr_pkg::*;

    localparam int AW = LO_W + 1;
    localparam int TW = LO_W + 3;

    typedef struct packed {
        logic standby;
    } top_t;

    top_t          st_d, st_q;
    acc_t          acc;
    logic          wr_cond, rd_cond, rd_valid, commit;
    logic [AW-1:0] eff_addr, commit_addr;
    logic [DW-1:0] commit_data;
    logic [TW-1:0] tag;

    dsr_addr_mux #(.LO_W(LO_W)) u_mux (
        .addr_lo (addr_lo),
        .hi_main (hi_main),
        .hi_alt  (hi_alt),
        .half_sel(half_sel),
        .eff_addr(eff_addr)
    );

    always_comb begin
        acc     = decode_access(en_lo_n, en_hi, oe_n, we_n);
        wr_cond = (acc == ACC_WRITE);
        rd_cond = (acc == ACC_READ);
        tag     = {addr_lo, hi_main, hi_alt, half_sel};
        st_d         = st_q;
        st_d.standby = (acc == ACC_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{standby: 1'b1};
        else        st_q <= st_d;
    end

    dsr_wr_window #(.AW(AW), .DW(DW), .TW(TW)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cond    (wr_cond),
        .eff_addr   (eff_addr),
        .tag        (tag),
        .wdata      (wdata),
        .commit     (commit),
        .commit_addr(commit_addr),
        .commit_data(commit_data),
        .proto_err  (proto_err)
    );

    dsr_array #(.AW(AW), .DW(DW)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_addr(commit_addr),
        .commit_data(commit_data),
        .rd_req     (rd_cond),
        .rd_addr    (eff_addr),
        .rdata      (rdata),
        .rd_valid   (rd_valid)
    );

    assign standby  = st_q.standby;
    assign drive_en = rd_valid && rd_cond;

    // R6: the bus is never driven while the write strobe is low
    p_no_drive_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> we_n);
    // R2: standby and bus drive never coincide
    p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !drive_en);
    // R3: output-disable mode keeps the bus undriven
    p_oe_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_lo_n && en_hi && we_n && oe_n) |-> !drive_en);
    // R4: driving requires a read sampled on the previous edge
    p_drive_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> ($past(!en_lo_n && en_hi && we_n && !oe_n)));
endmodule

// File: tb/tb_dsp_bank_sram.sv
`timescale 1ns/1ps
module tb_dsp_bank_sram;
    localparam int LO_W = 10;
    localparam int DW   = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [LO_W-1:0] addr_lo = '0;
    logic            hi_main = 1'b0, hi_alt = 1'b0, half_sel = 1'b0;
    logic            en_lo_n = 1'b1, en_hi = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            drive_en, standby, proto_err;

    int checks = 0, failures = 0;
    bit done = 0, reported = 0;
    logic [DW-1:0] model [int];
    logic [DW-1:0] expq [$];

    always #2.5 clk = ~clk;

    dsp_bank_sram #(.LO_W(LO_W), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .hi_main(hi_main),
        .hi_alt(hi_alt), .half_sel(half_sel), .en_lo_n(en_lo_n), .en_hi(en_hi),
        .oe_n(oe_n), .we_n(we_n), .wdata(wdata), .rdata(rdata),
        .drive_en(drive_en), .standby(standby), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endtask

    function automatic int eff(input int lo, input bit hm, input bit ha, input bit pk);
        return ((pk ? int'(ha) : int'(hm)) << LO_W) | lo;
    endfunction

    // monitor: every driven cycle must match the oldest expected read
    always @(negedge clk) begin
        if (rst_n && drive_en) begin
            if (expq.size() == 0) chk(0, "R4", "unexpected drive", 1, 0);
            else begin
                logic [DW-1:0] e;
                e = expq.pop_front();
                chk(rdata === e, "R4", "read data", rdata, e);
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic set_addr(input int lo, input bit hm, input bit ha, input bit pk);
        addr_lo = lo[LO_W-1:0]; hi_main = hm; hi_alt = ha; half_sel = pk;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            en_lo_n = 1; en_hi = 0; we_n = 1; oe_n = 1;
        end
    endtask

    // two-clock write window, then closed by method kind (0 strobe, 1 low enable, 2 high enable)
    task automatic wr(input int lo, input bit hm, input bit ha, input bit pk,
                      input logic [DW-1:0] d, input int kind, input bit oe);
        step();
        set_addr(lo, hm, ha, pk); wdata = d;
        en_lo_n = 0; en_hi = 1; we_n = 0; oe_n = oe;
        @(negedge clk);
        chk(drive_en == 0, "R6", "drive during write", drive_en, 0);
        #1;
        @(negedge clk);
        chk(drive_en == 0, "R6", "drive during write", drive_en, 0);
        #1;
        oe_n = 1;
        case (kind)
            0: we_n = 1;
            1: en_lo_n = 1;
            default: en_hi = 0;
        endcase
        model[eff(lo, hm, ha, pk)] = d;
    endtask

    task automatic rd(input int lo, input bit hm, input bit ha, input bit pk);
        step();
        set_addr(lo, hm, ha, pk);
        en_lo_n = 0; en_hi = 1; we_n = 1; oe_n = 0;
        expq.push_back(model[eff(lo, hm, ha, pk)]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        // reset state (R2)
        repeat (3) @(negedge clk);
        chk(standby == 1, "R2", "standby in reset", standby, 1);
        chk(drive_en == 0, "R2", "drive in reset", drive_en, 0);
        chk(proto_err == 0, "R2", "err in reset", proto_err, 0);
        chk(rdata == 0, "R2", "rdata in reset", rdata, 0);
        #1 rst_n = 1;
        idle(2);
        @(negedge clk);
        chk(standby == 1, "R2", "standby while deselected", standby, 1);

        // writes closed by each of the three methods, oe low in one (R5)
        wr(5, 0, 0, 0, 24'hA0A0A5, 0, 1);
        wr(5, 1, 0, 0, 24'hB1B1B5, 1, 0);
        wr(7, 0, 1, 1, 24'hC2C2C7, 2, 1);
        wr(7, 0, 0, 0, 24'hD3D3D7, 0, 1);
        idle(1);

        // back-to-back reads through both top-bit candidates (R1, R4)
        rd(5, 0, 0, 0);
        rd(5, 1, 0, 0);
        rd(7, 1, 0, 0);   // R1: same word as alt path with half_sel=1
        rd(7, 0, 1, 0);   // R1: hi_alt ignored when half_sel=0
        rd(5, 1, 0, 1);   // R1: hi_main ignored when half_sel=1
        idle(1);

        // R4 drive drops in the same cycle; R9 hold; R3 quiet mode
        rd(5, 0, 0, 0);
        @(negedge clk); #1;
        oe_n = 1;
        #1 chk(drive_en == 0, "R4", "drive drop same cycle", drive_en, 0);
        @(negedge clk);
        chk(rdata == 24'hA0A0A5, "R9", "rdata held", rdata, 24'hA0A0A5);
        chk(drive_en == 0, "R3", "output disable", drive_en, 0);
        chk(standby == 0, "R3", "standby while selected", standby, 0);

        // R2: deselected write attempt has no effect
        #1;
        set_addr(5, 0, 0, 0); wdata = 24'h0BAD00;
        en_lo_n = 0; en_hi = 0; we_n = 0; oe_n = 0;
        @(negedge clk);
        chk(drive_en == 0, "R2", "drive while deselected", drive_en, 0);
        chk(standby == 1, "R2", "standby high", standby, 1);
        #1 en_lo_n = 1; en_hi = 1;
        @(negedge clk);
        chk(standby == 1, "R2", "standby via low enable", standby, 1);
        #1 we_n = 1; oe_n = 1;
        rd(5, 0, 0, 0);
        idle(1);

        // R7: address and select changes inside a window; last sample commits (R5)
        wr(20, 0, 0, 0, 24'h202020, 0, 1);
        step();
        set_addr(20, 0, 0, 0); wdata = 24'hE0E0E0;
        en_lo_n = 0; en_hi = 1; we_n = 0; oe_n = 1;
        step();
        set_addr(21, 0, 0, 0);
        @(negedge clk);
        chk(proto_err == 1, "R7", "err on address change", proto_err, 1);
        #1 wdata = 24'hF1F1F1;
        @(negedge clk);
        chk(proto_err == 0, "R7", "err single pulse", proto_err, 0);
        #1 half_sel = 1;
        @(negedge clk);
        chk(proto_err == 1, "R7", "err on select change", proto_err, 1);
        #1 we_n = 1;
        model[eff(21, 0, 0, 1)] = 24'hF1F1F1;
        @(negedge clk);
        chk(proto_err == 0, "R7", "err clear after close", proto_err, 0);
        rd(20, 0, 0, 0);  // R5: the first address is untouched
        rd(21, 0, 0, 1);  // R5: last sampled address and data
        idle(1);

        // R8: read on the committing edge returns the new word
        wr(30, 0, 0, 0, 24'h303030, 0, 1);
        step();
        set_addr(30, 0, 0, 0); wdata = 24'h8E8E8E;
        en_lo_n = 0; en_hi = 1; we_n = 0; oe_n = 0;
        @(negedge clk);
        chk(drive_en == 0, "R6", "drive with oe low in write", drive_en, 0);
        #1 we_n = 1;
        model[30] = 24'h8E8E8E;
        expq.push_back(24'h8E8E8E);
        idle(2);

        @(negedge clk);
        chk(expq.size() == 0, "R4", "all expected reads seen", expq.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule